// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block decides which clocks of a small processor core run. The core normally runs at full speed. When the core retires a standby or suspend instruction at writeback, it sends the block a one-cycle request. The block then takes the core into a low-power state through an ordered handshake with the internal bus and the DRAM controller. In standby only the core pipeline clocks stop, so peripherals and their DMA keep working. In suspend the DRAM is first placed in self-refresh, then the core clocks stop, and the peripheral clock stops last.

The timer, interrupt and bus-master clock enables never drop, so an interrupt can always be seen. Any interrupt, including one from the internal timer, brings the core back to full speed. If the interrupt arrives while the block is still entering a low-power state, that entry is abandoned.

Every clock enable and the self-refresh request come straight from flip-flops. The gating cells downstream therefore only ever see changes at clock edges. A 2-bit mode output reports the current state.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is held and on the first edge after it is released, every core clock enable, the peripheral, timer, interrupt and bus-master clock enables are 1, the self-refresh request is 0 and the mode is full speed (00).
- R2: After a standby request, the core clock enables stay 1 until the bus idle flag has been sampled high. They drop on the clock edge that samples it, and the mode becomes standby (01) on that same edge.
- R3: In standby, the peripheral clock enable stays 1 and no self-refresh request is raised.
- R4: After a suspend request, the block raises the self-refresh request first. It then waits for the self-refresh acknowledge, and only after that for bus idle. The core clock enables drop on the edge that samples idle. The peripheral clock enable drops one edge later, and the mode becomes suspend (10) on that edge.
- R5: The timer, interrupt and bus-master clock enables are 1 in every state.
- R6: An interrupt sampled in standby restores all core clock enables and sets the mode to full speed (00) on the same edge.
- R7: An interrupt sampled in suspend turns the core and peripheral clock enables back on and clears the self-refresh request on that edge. The mode stays at suspend (10) until the acknowledge is sampled low, and becomes full speed on that edge.
- R8: An interrupt sampled during either entry handshake, before the low-power state is reached, returns the block to full speed on that edge. All enables are then 1 and the self-refresh request is 0.
- R9: Standby and suspend requests that arrive while the block is not in the full-speed idle state have no effect.
- R10: If both requests arrive in the same cycle at full speed, suspend is the one taken.
- R11: The mode output uses the codes 00 full speed, 01 standby and 10 suspend. Code 11 is kept for hibernate and is never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (free-running) |
| rst_n | input | 1 | Synchronous active-low reset |
| standby_req_i | input | 1 | One-cycle pulse: standby instruction retired |
| suspend_req_i | input | 1 | One-cycle pulse: suspend instruction retired |
| bus_idle_i | input | 1 | Internal bus has no transfer in flight |
| sr_ack_i | input | 1 | DRAM is in self-refresh (level) |
| irq_i | input | 1 | Any pending interrupt, internal timer included |
| core_clk_en_o | output | CORE_CLK_W | Enables for the core pipeline clocks |
| periph_clk_en_o | output | 1 | Enable for the peripheral clock |
| tmr_clk_en_o | output | 1 | Enable for the timer clock |
| irq_clk_en_o | output | 1 | Enable for the interrupt clock |
| bus_mst_clk_en_o | output | 1 | Enable for the bus master clock |
| sr_req_o | output | 1 | Request DRAM self-refresh |
| mode_o | output | 2 | Current power mode code |

## Verification
The assertions check several rules on every cycle. The always-on enables never drop. The core enables never fall unless bus idle was sampled on that edge. The peripheral enable only falls after the core is off and self-refresh is requested. Any interrupt seen in a low-power mode reopens the core and peripheral clocks on the next edge. The hibernate code never appears. Only the bench scenarios can show the rest: the exact waiting behaviour against idle and acknowledge, the suspend-over-standby choice, that requests are ignored mid-transition, and the exit wait on the acknowledge.

// File: rtl/pwr_mode_pkg.sv
// Shared types for the power mode sequencing controller.
// Assumes: nothing beyond a standard SystemVerilog elaborator.
package pwr_mode_pkg;

    // Sequencer states; the order of the handshake lives in the FSM transitions.
    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,  // full speed, accepting requests
        ST_SB_IDLEW  = 3'd1,  // standby entry: waiting for bus idle
        ST_SB_LOW    = 3'd2,  // standby: core clocks stopped
        ST_SP_SRW    = 3'd3,  // suspend entry: waiting for self-refresh ack
        ST_SP_IDLEW  = 3'd4,  // suspend entry: waiting for bus idle
        ST_SP_COREX  = 3'd5,  // suspend entry: core stopped, peripheral next
        ST_SP_LOW    = 3'd6,  // suspend: core and peripheral clocks stopped
        ST_SP_EXIT   = 3'd7   // suspend exit: waiting for self-refresh release
    } seq_state_t;

    // Reported mode codes.
    typedef enum logic [1:0] {
        MODE_FULL      = 2'b00,
        MODE_STANDBY   = 2'b01,
        MODE_SUSPEND   = 2'b10,
        MODE_HIBERNATE = 2'b11   // reserved, never produced here
    } pwr_mode_t;

endpackage

// File: rtl/pwr_seq_fsm.sv
// Sequencer for power mode transitions.
// Holds the current state and produces the next state combinationally so the
// clock-enable bank can register outputs that line up with the state register.
// Also registers the reported mode code.
// Assumes: request pulses last one cycle; sr_ack_i is a level from the DRAM side.
module pwr_seq_fsm
    import pwr_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       standby_req_i,
    input  logic       suspend_req_i,
    input  logic       bus_idle_i,
    input  logic       sr_ack_i,
    input  logic       irq_i,
    output seq_state_t state_d,
    output logic [1:0] mode_q
);

    seq_state_t state_q;
    pwr_mode_t  mode_d;

    // Next-state selection: entry handshake order, abort and wake rules.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (suspend_req_i)      state_d = ST_SP_SRW;   // suspend wins a tie
                else if (standby_req_i) state_d = ST_SB_IDLEW;
            end
            ST_SB_IDLEW: begin
                if (irq_i)           state_d = ST_RUN;
                else if (bus_idle_i) state_d = ST_SB_LOW;
            end
            ST_SB_LOW: begin
                if (irq_i) state_d = ST_RUN;
            end
            ST_SP_SRW: begin
                if (irq_i)         state_d = ST_RUN;
                else if (sr_ack_i) state_d = ST_SP_IDLEW;
            end
            ST_SP_IDLEW: begin
                if (irq_i)           state_d = ST_RUN;
                else if (bus_idle_i) state_d = ST_SP_COREX;
            end
            ST_SP_COREX: begin
                if (irq_i) state_d = ST_RUN;
                else       state_d = ST_SP_LOW;
            end
            ST_SP_LOW: begin
                if (irq_i) state_d = ST_SP_EXIT;
            end
            ST_SP_EXIT: begin
                if (!sr_ack_i) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // Mode code that belongs to the next state.
    always_comb begin
        unique case (state_d)
            ST_SB_LOW:              mode_d = MODE_STANDBY;
            ST_SP_LOW, ST_SP_EXIT:  mode_d = MODE_SUSPEND;
            default:                mode_d = MODE_FULL;
        endcase
    end

    // State and mode registers, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            mode_q  <= MODE_FULL;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end

endmodule

// File: rtl/pwr_clk_en_bank.sv
// Registered clock-enable bank.
// Decodes the sequencer's next state into enables and the self-refresh request,
// all held in flops so the downstream gating cells see edge-aligned changes only.
// Assumes: state_d is the value the sequencer's state register loads this edge.
module pwr_clk_en_bank
    import pwr_mode_pkg::*;
#(
    parameter int CORE_CLK_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  seq_state_t            state_d,
    output logic [CORE_CLK_W-1:0] core_en_q,
    output logic                  periph_en_q,
    output logic                  tmr_en_q,
    output logic                  irq_en_q,
    output logic                  bus_mst_en_q,
    output logic                  sr_req_q
);

    logic core_on_d;
    logic periph_on_d;
    logic sr_req_d;

    // Decode which clocks the next state keeps running.
    always_comb begin
        core_on_d   = !(state_d inside {ST_SB_LOW, ST_SP_COREX, ST_SP_LOW});
        periph_on_d = (state_d != ST_SP_LOW);
        sr_req_d    = state_d inside {ST_SP_SRW, ST_SP_IDLEW, ST_SP_COREX, ST_SP_LOW};
    end

    // One flop per core clock enable, so each gating cell has its own driver.
    for (genvar gi = 0; gi < CORE_CLK_W; gi++) begin : g_core_en
        always_ff @(posedge clk) begin
            if (!rst_n) core_en_q[gi] <= 1'b1;
            else        core_en_q[gi] <= core_on_d;
        end
    end

    // Peripheral enable and self-refresh request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            periph_en_q <= 1'b1;
            sr_req_q    <= 1'b0;
        end else begin
            periph_en_q <= periph_on_d;
            sr_req_q    <= sr_req_d;
        end
    end

    // Always-on domains: registered for uniform output timing, never cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_en_q     <= 1'b1;
            irq_en_q     <= 1'b1;
            bus_mst_en_q <= 1'b1;
        end else begin
            tmr_en_q     <= 1'b1;
            irq_en_q     <= 1'b1;
            bus_mst_en_q <= 1'b1;
        end
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Power mode sequencing controller, top level.
// Moves the core between full speed, standby and suspend through ordered
// handshakes with the bus and DRAM; interrupts wake or abort.
// Assumes: all inputs synchronous to clk; request pulses one cycle wide.
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int CORE_CLK_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  standby_req_i,
    input  logic                  suspend_req_i,
    input  logic                  bus_idle_i,
    input  logic                  sr_ack_i,
    input  logic                  irq_i,
    output logic [CORE_CLK_W-1:0] core_clk_en_o,
    output logic                  periph_clk_en_o,
    output logic                  tmr_clk_en_o,
    output logic                  irq_clk_en_o,
    output logic                  bus_mst_clk_en_o,
    output logic                  sr_req_o,
    output logic [1:0]            mode_o
);

    seq_state_t state_d;

    // Sequencer: state and mode.
    pwr_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .standby_req_i (standby_req_i),
        .suspend_req_i (suspend_req_i),
        .bus_idle_i    (bus_idle_i),
        .sr_ack_i      (sr_ack_i),
        .irq_i         (irq_i),
        .state_d       (state_d),
        .mode_q        (mode_o)
    );

    // Registered enables and self-refresh request.
    pwr_clk_en_bank #(.CORE_CLK_W(CORE_CLK_W)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_d      (state_d),
        .core_en_q    (core_clk_en_o),
        .periph_en_q  (periph_clk_en_o),
        .tmr_en_q     (tmr_clk_en_o),
        .irq_en_q     (irq_clk_en_o),
        .bus_mst_en_q (bus_mst_clk_en_o),
        .sr_req_q     (sr_req_o)
    );

    AST_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clk_en_o && irq_clk_en_o && bus_mst_clk_en_o);                    // R5
    AST_CORE_OFF_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_clk_en_o[0]) |-> $past(bus_idle_i));                       // R2
    AST_PERIPH_OFF_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(periph_clk_en_o) |-> ($past(core_clk_en_o) == '0) && $past(sr_req_o)); // R4
    AST_STANDBY_KEEPS_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_STANDBY) |-> periph_clk_en_o && !sr_req_o);          // R3
    AST_WAKE_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != MODE_FULL && irq_i) |=> (&core_clk_en_o) && periph_clk_en_o && !sr_req_o); // R6
    AST_NO_HIBERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != MODE_HIBERNATE);                                            // R11

endmodule

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;

    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stb = 1'b0, sus = 1'b0, idle = 1'b0, ack = 1'b0, irq = 1'b0;
    logic [CW-1:0] core_en;
    logic          per_en, tmr_en, irq_en, bm_en, sr_req;
    logic [1:0]    mode;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    pwr_mode_ctrl #(.CORE_CLK_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .standby_req_i(stb), .suspend_req_i(sus), .bus_idle_i(idle),
        .sr_ack_i(ack), .irq_i(irq),
        .core_clk_en_o(core_en), .periph_clk_en_o(per_en),
        .tmr_clk_en_o(tmr_en), .irq_clk_en_o(irq_en),
        .bus_mst_clk_en_o(bm_en), .sr_req_o(sr_req), .mode_o(mode)
    );

    // Vector: [13]stb [12]sus [11]idle [10]ack [9]irq | expected after edge:
    // [8]core [7]periph [6]sr_req [5:4]mode | [3:0] requirement number
    localparam int NV = 24;
    localparam logic [13:0] VEC [0:NV-1] = '{
        14'b10000_110_00_0010, // R2 standby request, bus busy
        14'b00000_110_00_0010, // R2 still waiting for idle
        14'b00100_010_01_0010, // R2 idle sampled: core off, standby
        14'b00000_010_01_0011, // R3 periph on, no sr
        14'b01000_010_01_1001, // R9 suspend request ignored in standby
        14'b00001_110_00_0110, // R6 interrupt wakes
        14'b01100_111_00_0100, // R4 suspend: sr first, idle ignored
        14'b00100_111_00_0100, // R4 waiting for ack
        14'b00010_111_00_0100, // R4 ack seen, wait idle
        14'b00010_111_00_0100, // R4 still busy
        14'b00110_011_00_0100, // R4 idle: core off
        14'b00010_001_10_0100, // R4 periph off, suspend
        14'b10010_001_10_1001, // R9 standby ignored in suspend
        14'b00011_110_10_0111, // R7 wake: clocks back, sr released
        14'b00010_110_10_0111, // R7 wait for ack release
        14'b00000_110_00_0111, // R7 ack low: full speed
        14'b11000_111_00_1010, // R10 both requests: suspend taken
        14'b00001_110_00_1000, // R8 abort while waiting ack
        14'b10000_110_00_1000, // R8 standby entry started
        14'b00001_110_00_1000, // R8 abort while waiting idle
        14'b01000_111_00_1000, // R8 suspend entry
        14'b00010_111_00_1000, // R8 ack
        14'b00110_011_00_1000, // R8 core off
        14'b00011_110_00_1000  // R8 abort after core off: full speed
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_full(input string req);
        chk(req, "core_en", int'(core_en), (1 << CW) - 1);
        chk(req, "periph_en", int'(per_en), 1);
        chk(req, "sr_req", int'(sr_req), 0);
        chk(req, "mode", int'(mode), 0);
        chk(req, "always_on", int'({tmr_en, irq_en, bm_en}), 7);
    endtask

    task automatic drive(input logic [4:0] v);
        @(negedge clk);
        {stb, sus, idle, ack, irq} = v;
        @(posedge clk);
        #1;
        {stb, sus, idle, ack, irq} = 5'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: state while reset is held, then just after release
        repeat (3) @(posedge clk);
        #1;
        chk_full("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk_full("R1");
        chk("R11", "mode code full", int'(mode), 0);

        // Interrupt at full speed changes nothing
        drive(5'b00001);
        chk_full("R6");

        // Table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            drive(VEC[i][13:9]);
            tag = $sformatf("R%0d", VEC[i][3:0]);
            chk(tag, $sformatf("core_en vec%0d", i), int'(core_en), VEC[i][8] ? (1 << CW) - 1 : 0);
            chk(tag, $sformatf("periph_en vec%0d", i), int'(per_en), int'(VEC[i][7]));
            chk(tag, $sformatf("sr_req vec%0d", i), int'(sr_req), int'(VEC[i][6]));
            chk(tag, $sformatf("mode vec%0d", i), int'(mode), int'(VEC[i][5:4]));
            chk("R5", $sformatf("always_on vec%0d", i), int'({tmr_en, irq_en, bm_en}), 7);
            chk("R11", $sformatf("no code 3 vec%0d", i), int'(mode == 2'b11), 0);
        end

        // Directed: reset while in suspend returns everything to full speed (R1)
        drive(5'b01000);
        drive(5'b00010);
        drive(5'b00110);
        drive(5'b00010);
        chk("R4", "reached suspend", int'(mode), 2);
        @(negedge clk);
        rst_n = 1'b0;
        ack = 1'b1;
        @(posedge clk);
        #1;
        chk_full("R1");
        @(negedge clk);
        rst_n = 1'b1;
        ack = 1'b0;
        @(posedge clk);
        #1;
        chk_full("R1");

        // Directed: long bus busy stretch in standby entry (R2)
        drive(5'b10000);
        for (int k = 0; k < 20; k++) drive(5'b00000);
        chk("R2", "core still on while busy", int'(core_en), (1 << CW) - 1);
        drive(5'b00100);
        chk("R2", "core off after idle", int'(core_en), 0);
        chk("R3", "periph on in standby", int'(per_en), 1);
        drive(5'b00001);
        chk_full("R6");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule